// File: doc/BRIEF.md
# Fixed Common-Mode Three-Level PWM Gate Generator

This block drives the gates of a three-phase, three-level neutral-point-clamped inverter. Each phase leg has two gate bits. The upper bit (`q1`) ties the output to the positive rail. The lower bit (`q2`) keeps the output away from the negative rail. The three leg states are:

- P: `q1=1`, `q2=1`
- O: `q1=0`, `q2=1`
- N: `q1=0`, `q2=0`

The generator only ever emits the all-O state or one of the six vectors in which one phase sits at P, one at O and one at N. All of these vectors give the same common-mode voltage, half the DC link, so the ground leakage current caused by common-mode swings goes away.

On every clock the generator ranks the three signed references as largest, middle and smallest. The largest is compared against an upper triangular carrier that runs from 0 to +1. The smallest is compared against a lower carrier that runs from -1 to 0. Both carriers come from one shared up/down counter, so they stay in phase. The middle leg's gates are computed from the two comparison results. A per-phase selector then routes each gate pair back to phases A, B and C, and the result is registered.

When the references are driven well past full scale, the comparisons saturate. The output then settles into a four-step pattern: the largest phase at P, the smallest at N and the middle at O.

Top module: `cmpwm_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every phase is at O (`gate_q1=3'b000`, `gate_q2=3'b111`). A reset also restarts the carrier counter at zero, counting up.
- R2: The references are strictly ordered on every cycle. A phase outranks another if its value is greater. On equal values, the phase with the higher priority wins, where A outranks B and B outranks C. The result is exactly one largest, one middle and one smallest phase.
- R3: The largest phase has `q2=1` at all times. Its `q1` is 1 exactly when its reference is strictly greater than the upper carrier.
- R4: The smallest phase has `q1=0` at all times. Its `q2` is 1 exactly when its reference is strictly greater than the lower carrier.
- R5: The middle phase's gates depend on the largest phase's `q1` (a) and the smallest phase's `q2` (b). Its `q1` is NOR(a, b) and its `q2` is NAND(a, b).
- R6: Outside reset, every output vector is either all-O or contains exactly one P, one O and one N. The pair `q1=1`, `q2=0` never appears on any phase.
- R7: Full scale is 2^(REF_W-2). The counter follows 0, 1, …, 2^CAR_BITS, then counts down to 1, and repeats from 0. The upper carrier is the count times 2^(REF_W-2-CAR_BITS). The lower carrier is the upper carrier minus full scale.
- R8: Gate bits at bit index 0, 1 and 2 belong to phases A, B and C. They are registered, and reflect the references and carrier value present at the previous rising clock edge.
- R9: Suppose the largest reference is above full scale and the smallest is below minus full scale. Then, on every cycle of the carrier, the largest phase is at P, the smallest at N and the middle at O.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a | input | REF_W | Signed reference, phase A |
| ref_b | input | REF_W | Signed reference, phase B |
| ref_c | input | REF_W | Signed reference, phase C |
| gate_q1 | output | 3 | Upper gate bits, bit 0 = A, bit 2 = C |
| gate_q2 | output | 3 | Lower gate bits, bit 0 = A, bit 2 = C |

## Verification
The assertions check the following on every cycle:

- The registered outputs never contain a forbidden gate pair.
- The count of P legs always equals the count of N legs and is at most one, so the common-mode level stays fixed.
- The ranking always yields one largest and one smallest phase, and equal references respect the A-B-C priority.
- The carrier stays in range and moves by exactly one step per clock.

Whether each leg lands at the right level on each carrier step can only be shown by the bench's scenarios. These cover:

- constant linear references;
- a rotating sweep that reorders the phases every cycle;
- ties;
- a reference exactly at full scale;
- saturated four-step drive;
- a reset in the middle of a run.

// File: rtl/cmpwm_pkg.sv
`timescale 1ns/1ps
package cmpwm_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        RANK_MIN = 2'd0,
        RANK_MID = 2'd1,
        RANK_MAX = 2'd2
    } rank_e;

    typedef struct packed {
        logic q1;
        logic q2;
    } gate_t;

    localparam gate_t GATE_O = '{q1: 1'b0, q2: 1'b1};

    function automatic gate_t top_leg(input logic above);
        return '{q1: above, q2: 1'b1};
    endfunction

    function automatic gate_t bottom_leg(input logic above);
        return '{q1: 1'b0, q2: above};
    endfunction

    function automatic gate_t middle_leg(input logic top_q1, input logic bot_q2);
        return '{q1: ~(top_q1 | bot_q2), q2: ~(top_q1 & bot_q2)};
    endfunction

endpackage

// File: rtl/cmpwm_carrier.sv
`timescale 1ns/1ps
module cmpwm_carrier
    import cmpwm_pkg::*;
#(
    parameter int REF_W    = 16,
    parameter int CAR_BITS = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic signed [REF_W-1:0] car_hi,
    output logic signed [REF_W-1:0] car_lo
);
    localparam int CW    = CAR_BITS + 1;
    localparam int SHIFT = REF_W - 2 - CAR_BITS;
    localparam logic [CW-1:0] PEAK = CW'(1 << CAR_BITS);
    localparam logic signed [REF_W-1:0] FULL = REF_W'(1 << (REF_W - 2));

    logic [CW-1:0]    cnt;
    logic             rising;
    logic [REF_W-1:0] hi_u;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            cnt <= cnt + 1'b1;
            if (cnt == PEAK - 1'b1) rising <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) rising <= 1'b1;
        end
    end

    assign hi_u   = {{(REF_W-CW){1'b0}}, cnt} << SHIFT;
    assign car_hi = signed'(hi_u);
    assign car_lo = car_hi - FULL;

    assert_carrier_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= PEAK);

    assert_carrier_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

endmodule

// File: rtl/cmpwm_rank_sort.sv
`timescale 1ns/1ps
module cmpwm_rank_sort
    import cmpwm_pkg::*;
#(
    parameter int REF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] ref_v [NPH],
    output rank_e                   rank  [NPH],
    output logic signed [REF_W-1:0] v_max,
    output logic signed [REF_W-1:0] v_min
);
    logic [NPH-1:0] is_max;
    logic [NPH-1:0] is_min;

    for (genvar i = 0; i < NPH; i++) begin : g_rank
        logic [1:0] wins;
        always_comb begin
            wins = '0;
            for (int j = 0; j < NPH; j++) begin
                if (j != i) begin
                    if ((ref_v[i] > ref_v[j]) || ((ref_v[i] == ref_v[j]) && (i < j)))
                        wins = wins + 2'd1;
                end
            end
        end
        assign rank[i]   = rank_e'(wins);
        assign is_max[i] = (rank[i] == RANK_MAX);
        assign is_min[i] = (rank[i] == RANK_MIN);
    end

    always_comb begin
        v_max = '0;
        v_min = '0;
        for (int k = 0; k < NPH; k++) begin
            if (is_max[k]) v_max = ref_v[k];
            if (is_min[k]) v_min = ref_v[k];
        end
    end

    assert_single_extremes_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(is_max) == 1) && ($countones(is_min) == 1));

    assert_tie_priority_R2: assert property (@(posedge clk) disable iff (rst)
        (ref_v[0] == ref_v[1]) |-> (rank[0] > rank[1]));

endmodule

// File: rtl/cmpwm_gate_core.sv
`timescale 1ns/1ps
module cmpwm_gate_core
    import cmpwm_pkg::*;
#(
    parameter int REF_W = 16
) (
    input  logic signed [REF_W-1:0] v_max,
    input  logic signed [REF_W-1:0] v_min,
    input  logic signed [REF_W-1:0] car_hi,
    input  logic signed [REF_W-1:0] car_lo,
    output gate_t                   g_max,
    output gate_t                   g_mid,
    output gate_t                   g_min
);
    logic top_above;
    logic bot_above;

    assign top_above = (v_max > car_hi);
    assign bot_above = (v_min > car_lo);

    assign g_max = top_leg(top_above);
    assign g_min = bottom_leg(bot_above);
    assign g_mid = middle_leg(top_above, bot_above);

endmodule

// File: rtl/cmpwm_phase_map.sv
`timescale 1ns/1ps
module cmpwm_phase_map
    import cmpwm_pkg::*;
(
    input  rank_e rank [NPH],
    input  gate_t g_max,
    input  gate_t g_mid,
    input  gate_t g_min,
    output gate_t g_ph [NPH]
);
    for (genvar p = 0; p < NPH; p++) begin : g_route
        always_comb begin
            case (rank[p])
                RANK_MAX: g_ph[p] = g_max;
                RANK_MIN: g_ph[p] = g_min;
                default:  g_ph[p] = g_mid;
            endcase
        end
    end

endmodule

// File: rtl/cmpwm_gen.sv
`timescale 1ns/1ps
module cmpwm_gen
    import cmpwm_pkg::*;
#(
    parameter int REF_W    = 16,
    parameter int CAR_BITS = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    output logic [NPH-1:0]          gate_q1,
    output logic [NPH-1:0]          gate_q2
);
    logic signed [REF_W-1:0] refs [NPH];
    logic signed [REF_W-1:0] car_hi, car_lo;
    logic signed [REF_W-1:0] v_max, v_min;
    rank_e                   rank [NPH];
    gate_t                   g_max, g_mid, g_min;
    gate_t                   g_ph [NPH];
    logic [NPH-1:0]          q1_r, q2_r;

    assign refs[0] = ref_a;
    assign refs[1] = ref_b;
    assign refs[2] = ref_c;

    cmpwm_carrier #(.REF_W(REF_W), .CAR_BITS(CAR_BITS)) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .car_hi (car_hi),
        .car_lo (car_lo)
    );

    cmpwm_rank_sort #(.REF_W(REF_W)) u_sort (
        .clk   (clk),
        .rst   (rst),
        .ref_v (refs),
        .rank  (rank),
        .v_max (v_max),
        .v_min (v_min)
    );

    cmpwm_gate_core #(.REF_W(REF_W)) u_core (
        .v_max  (v_max),
        .v_min  (v_min),
        .car_hi (car_hi),
        .car_lo (car_lo),
        .g_max  (g_max),
        .g_mid  (g_mid),
        .g_min  (g_min)
    );

    cmpwm_phase_map u_map (
        .rank  (rank),
        .g_max (g_max),
        .g_mid (g_mid),
        .g_min (g_min),
        .g_ph  (g_ph)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q1_r <= {NPH{GATE_O.q1}};
            q2_r <= {NPH{GATE_O.q2}};
        end else begin
            for (int p = 0; p < NPH; p++) begin
                q1_r[p] <= g_ph[p].q1;
                q2_r[p] <= g_ph[p].q2;
            end
        end
    end

    assign gate_q1 = q1_r;
    assign gate_q2 = q2_r;

    assert_reset_all_o_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((gate_q1 == '0) && (gate_q2 == '1)));

    assert_no_bad_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (gate_q1 & ~gate_q2) == '0);

    assert_cm_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        ($countones(gate_q1) == $countones(~gate_q2)) && ($countones(gate_q1) <= 1));

endmodule

// File: tb/test_cmpwm_gen.sv
`timescale 1ns/1ps
module test_cmpwm_gen;
    localparam int REF_W    = 16;
    localparam int CAR_BITS = 6;
    localparam int PK       = 1 << CAR_BITS;
    localparam int FULL     = 1 << (REF_W - 2);
    localparam int STEP     = FULL / PK;
    localparam int PERIOD   = 2 * PK;

    typedef struct {
        logic [2:0] q1;
        logic [2:0] q2;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [REF_W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic [2:0] gate_q1, gate_q2;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int m_cnt  = 0;
    bit m_up   = 1;
    exp_t sb[$];

    always #10 clk = ~clk;

    cmpwm_gen #(.REF_W(REF_W), .CAR_BITS(CAR_BITS)) i_cmpwm_gen (
        .clk     (clk),
        .rst     (rst),
        .ref_a   (ref_a),
        .ref_b   (ref_b),
        .ref_c   (ref_c),
        .gate_q1 (gate_q1),
        .gate_q2 (gate_q2)
    );

    // Independent triangle model (R7)
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0;
            m_up  <= 1;
        end else if (m_up) begin
            m_cnt <= m_cnt + 1;
            if (m_cnt == PK - 1) m_up <= 0;
        end else begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) m_up <= 1;
        end
    end

    function automatic void predict(input int a, input int b, input int c, input int cnt,
                                    output logic [2:0] q1, output logic [2:0] q2);
        int r[3];
        int rk[3];
        int hi, lo, vmax, vmin;
        bit cmx, cmn;
        r[0] = a; r[1] = b; r[2] = c;
        for (int i = 0; i < 3; i++) begin
            rk[i] = 0;
            for (int j = 0; j < 3; j++)
                if (j != i && ((r[i] > r[j]) || (r[i] == r[j] && i < j))) rk[i]++;
        end
        vmax = 0; vmin = 0;
        for (int i = 0; i < 3; i++) begin
            if (rk[i] == 2) vmax = r[i];
            if (rk[i] == 0) vmin = r[i];
        end
        hi  = cnt * STEP;
        lo  = hi - FULL;
        cmx = (vmax > hi);
        cmn = (vmin > lo);
        for (int i = 0; i < 3; i++) begin
            if (rk[i] == 2) begin q1[i] = cmx; q2[i] = 1'b1; end
            else if (rk[i] == 0) begin q1[i] = 1'b0; q2[i] = cmn; end
            else begin q1[i] = ~(cmx | cmn); q2[i] = ~(cmx & cmn); end
        end
    endfunction

    task automatic step(input int a, input int b, input int c, input bit r, input string tag);
        exp_t e;
        @(negedge clk);
        rst   = r;
        ref_a = REF_W'(a);
        ref_b = REF_W'(b);
        ref_c = REF_W'(c);
        if (r) begin
            e.q1 = 3'b000;
            e.q2 = 3'b111;
        end else begin
            predict(a, b, c, m_cnt, e.q1, e.q2);
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: legality every cycle, then scoreboard compare
    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            int np, nn;
            bit bad;
            np  = $countones(gate_q1);
            nn  = $countones(~gate_q2);
            bad = ((gate_q1 & ~gate_q2) != 3'b000) || (np != nn) || (np > 1);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL R6: vector q1=%b q2=%b, expected all-O or one P/O/N", gate_q1, gate_q2);
            end
        end
        if (sb.size() > 0 && !done) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (gate_q1 !== e.q1 || gate_q2 !== e.q2) begin
                errors++;
                $display("FAIL %s: q1=%b q2=%b expected q1=%b q2=%b",
                         e.tag, gate_q1, gate_q2, e.q1, e.q2);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) step(0, 0, 0, 1, "R1 reset");
        // R3 R4 R5 R7: constant linear references over two carrier periods
        repeat (2 * PERIOD) step(8000, -3000, -5000, 0, "R3 R4 R5 R7 linear");
        repeat (PERIOD) step(-6000, 9000, -3000, 0, "R3 R4 R5 linear B max");
        // R2 R8: reordering sweep, references change every cycle
        for (int k = 0; k < 256; k++) begin
            int a, b;
            a = ((k * 37) % 20000) - 10000;
            b = ((k * 91) % 16000) - 8000;
            step(a, b, -(a + b), 0, "R2 R8 sweep");
        end
        // R2: ties resolved A > B > C
        repeat (PERIOD) step(5000, 5000, -10000, 0, "R2 tie A=B");
        repeat (PERIOD) step(-8000, 4000, 4000, 0, "R2 tie B=C");
        repeat (PERIOD) step(0, 0, 0, 0, "R2 R5 all equal");
        // R3: reference exactly at full scale
        repeat (PERIOD) step(FULL, -FULL / 2, -FULL / 2, 0, "R3 full scale");
        // R9: saturated four-step drive
        repeat (PERIOD + 4) step(20000, 0, -20000, 0, "R9 four-step A=P C=N");
        repeat (PERIOD + 4) step(-20000, 20000, 500, 0, "R9 four-step B=P A=N");
        // R1 R7: reset mid-run, carrier restarts at zero
        repeat (40) step(7000, -2000, -5000, 0, "R4 pre-reset");
        repeat (2) step(7000, -2000, -5000, 1, "R1 mid-run reset");
        repeat (PERIOD) step(7000, -2000, -5000, 0, "R7 restart");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule